// File: doc/BRIEF.md
# Superscalar Decode Stage with Group Skid Buffer

This block sits between fetch and rename in an in-order front end. Each cycle, fetch presents a group of up to `LANES` instruction slots. Each slot carries an opaque tag, a next-PC value and a few control flags. The stage drops slots that are already marked as killed and packs the survivors from output slot 0 upward. It also tags instructions that have no source operands as ready to issue. All outputs are registered, so a group presented before clock edge k appears at the outputs just after edge k.

Rename, execute or commit can hold the stage with a stall. While held, the stage parks whole fetch groups in a small skid buffer. It tells fetch to hold until the buffer has drained, and it drains the buffer oldest-first ahead of live input. A flush from commit discards the buffer and parks the stage until the flush is released. If a slot is a resolved control transfer with a wrong prediction, or a non-control instruction predicted taken, the stage forwards that slot and drops the remainder of the group. It then redirects fetch to that slot's next PC and enters the same flushed condition.

Top module: `dec_stage`

## Requirements
- R1: After reset the stage is idle, the skid buffer is empty, and every output is zero.
- R2: When processing without stall or flush, slots with `in_valid`=1 and `in_killed`=0 are forwarded in lane order, packed from output slot 0. `out_valid` is a thermometer mask, `out_count` gives their number, and the results appear one clock after the input. The idle state behaves exactly like the running state.
- R3: Each forwarded slot carries `out_ready`=1 exactly when its `in_no_src` bit was 1.
- R4: Any of `stall_rename`, `stall_exec` or `stall_commit` high while processing (and no flush) forwards nothing and raises `fetch_hold`. It also saves a non-empty live group into the skid buffer.
- R5: While blocked, every non-empty live group is saved and `fetch_hold` stays high. Once all three stalls are low, the stage starts unblocking, and `fetch_hold` is still high for that transition.
- R6: While unblocking, the oldest saved group is processed instead of the live input. A non-empty live group is appended and the oldest group is removed. `fetch_hold` stays high while groups remain, and the stage returns to running with `fetch_hold` low when the buffer is empty.
- R7: `flush_commit` or `flush_rob` high in any state other than flushed discards every saved group and forwards nothing. It also enters the flushed state with `fetch_hold` low, and takes priority over the stalls.
- R8: In the flushed state nothing is forwarded and live groups are discarded. The stage returns to running only in a cycle where both flush inputs are low.
- R9: The first surviving slot with (`in_is_ctrl` & `in_tgt_known` & `in_mispred`) or (`in_pred_taken` & !`in_is_ctrl`) is forwarded and later slots are dropped. `fetch_redirect` pulses with `fetch_redirect_pc` equal to that slot's `in_next_pc`, the buffer is cleared, and the stage enters the flushed state.
- R10: The skid buffer holds `SKID_DEPTH` groups. A push and a pop may coincide when it is full, and no saved group is lost when fetch respects a one-cycle-late view of `fetch_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Slot present in the fetch group |
| in_killed | input | LANES | Slot already squashed upstream |
| in_is_ctrl | input | LANES | Slot is a control transfer |
| in_tgt_known | input | LANES | Branch target already resolved |
| in_mispred | input | LANES | Resolved target disagrees with prediction |
| in_pred_taken | input | LANES | Fetch predicted this slot taken |
| in_no_src | input | LANES | Slot reads no source registers |
| in_tag | input | LANES*TAG_W | Opaque per-slot tag, lane 0 in low bits |
| in_next_pc | input | LANES*PC_W | Correct next PC per slot |
| stall_rename | input | 1 | Hold request from rename |
| stall_exec | input | 1 | Hold request from execute |
| stall_commit | input | 1 | Hold request from commit |
| flush_commit | input | 1 | Squash from commit |
| flush_rob | input | 1 | Reorder buffer is squashing |
| out_valid | output | LANES | Packed valid mask to rename |
| out_tag | output | LANES*TAG_W | Packed tags to rename |
| out_ready | output | LANES | Ready-to-issue mark per packed slot |
| out_count | output | $clog2(LANES+1) | Number of forwarded slots |
| fetch_hold | output | 1 | Tell fetch to stop sending |
| fetch_redirect | output | 1 | Decode-time mispredict redirect |
| fetch_redirect_pc | output | PC_W | Redirect target |

## Verification
Two pairs of functions can land in the same cycle. A stall and a commit flush can coincide, and a decode-time mispredict can be found in a group drained from the skid buffer while a live group is also arriving. The bench drives both coincidences directly: a stall together with a flush must leave no output, a low hold and a cleared buffer. It also stalls on a group carrying a mispredict, then releases the stall and presents a live group during the drain; the redirect must win and the live group must never reach rename. Random stall and flush traffic is mixed in, and every cycle is compared with a bench model.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_BLOCK, ST_UNBLK, ST_SQUASH
  } dec_state_e;

  // Layout of one lane word inside a stored group
  localparam int OFS_V    = 0;
  localparam int OFS_K    = 1;
  localparam int OFS_C    = 2;
  localparam int OFS_T    = 3;
  localparam int OFS_M    = 4;
  localparam int OFS_P    = 5;
  localparam int OFS_Z    = 6;
  localparam int OFS_TAG  = 7;

  function automatic int lane_width(input int tag_w, input int pc_w);
    return OFS_TAG + tag_w + pc_w;
  endfunction

  // A slot forces a fetch redirect when its resolved target was wrong,
  // or when a non-control instruction was predicted taken.
  function automatic logic lane_redirects(input logic ctrl, input logic tgt_known,
                                          input logic mispred, input logic pred_taken);
    return (ctrl && tgt_known && mispred) || (pred_taken && !ctrl);
  endfunction
endpackage

// File: rtl/dec_skid.sv
module dec_skid #(
  parameter int GW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [GW-1:0] din,
  output logic [GW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [GW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/dec_pack.sv
module dec_pack import dec_pkg::*; #(
  parameter int W      = 4,
  parameter int TAG_W  = 8,
  parameter int PC_W   = 16,
  localparam int LANE_W = OFS_TAG + TAG_W + PC_W,
  localparam int CNT_W  = $clog2(W + 1)
) (
  input  logic [W*LANE_W-1:0] grp,
  output logic [W-1:0]        o_valid,
  output logic [W-1:0]        o_ready,
  output logic [W*TAG_W-1:0]  o_tag,
  output logic [CNT_W-1:0]    o_count,
  output logic                o_redir,
  output logic [PC_W-1:0]     o_redir_pc
);
  always_comb begin
    logic stop;
    int   n;
    o_valid    = '0;
    o_ready    = '0;
    o_tag      = '0;
    o_redir    = 1'b0;
    o_redir_pc = '0;
    stop       = 1'b0;
    n          = 0;
    for (int i = 0; i < W; i++) begin
      logic [LANE_W-1:0] ln;
      ln = grp[i*LANE_W +: LANE_W];
      if (!stop && ln[OFS_V] && !ln[OFS_K]) begin
        o_tag[n*TAG_W +: TAG_W] = ln[OFS_TAG +: TAG_W];
        o_ready[n] = ln[OFS_Z];
        o_valid[n] = 1'b1;
        n = n + 1;
        if (lane_redirects(ln[OFS_C], ln[OFS_T], ln[OFS_M], ln[OFS_P])) begin
          stop       = 1'b1;
          o_redir    = 1'b1;
          o_redir_pc = ln[OFS_TAG+TAG_W +: PC_W];
        end
      end
    end
    o_count = CNT_W'(n);
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage import dec_pkg::*; #(
  parameter int LANES      = 4,
  parameter int TAG_W      = 8,
  parameter int PC_W       = 16,
  parameter int SKID_DEPTH = 4,
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      in_valid,
  input  logic [LANES-1:0]      in_killed,
  input  logic [LANES-1:0]      in_is_ctrl,
  input  logic [LANES-1:0]      in_tgt_known,
  input  logic [LANES-1:0]      in_mispred,
  input  logic [LANES-1:0]      in_pred_taken,
  input  logic [LANES-1:0]      in_no_src,
  input  logic [LANES*TAG_W-1:0] in_tag,
  input  logic [LANES*PC_W-1:0] in_next_pc,
  input  logic                  stall_rename,
  input  logic                  stall_exec,
  input  logic                  stall_commit,
  input  logic                  flush_commit,
  input  logic                  flush_rob,
  output logic [LANES-1:0]      out_valid,
  output logic [LANES*TAG_W-1:0] out_tag,
  output logic [LANES-1:0]      out_ready,
  output logic [CNT_W-1:0]      out_count,
  output logic                  fetch_hold,
  output logic                  fetch_redirect,
  output logic [PC_W-1:0]       fetch_redirect_pc
);
  localparam int LANE_W = lane_width(TAG_W, PC_W);
  localparam int GW     = LANES * LANE_W;
  localparam int SCW    = $clog2(SKID_DEPTH + 1);

  dec_state_e st_q, st_d;

  logic [GW-1:0]       grp_live, grp_head, grp_src;
  logic [SCW-1:0]      skid_count;
  logic                skid_full, skid_empty;
  logic                skid_push, skid_pop, skid_clr;
  logic                live_any, stall_any, flush_any;
  logic                emit, hold_d, redir_d;
  logic [LANES-1:0]    pk_valid, pk_ready;
  logic [LANES*TAG_W-1:0] pk_tag;
  logic [CNT_W-1:0]    pk_count;
  logic                pk_redir;
  logic [PC_W-1:0]     pk_pc;

  // Groups still buffered once the head leaves and a live group may join
  function automatic logic left_after_pop(input logic [SCW-1:0] cnt, input logic add);
    return (int'(cnt) + (add ? 1 : 0)) > 1;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign grp_live[i*LANE_W +: LANE_W] = {
      in_next_pc[i*PC_W +: PC_W], in_tag[i*TAG_W +: TAG_W],
      in_no_src[i], in_pred_taken[i], in_mispred[i], in_tgt_known[i],
      in_is_ctrl[i], in_killed[i], in_valid[i]};
  end

  assign live_any  = |in_valid;
  assign stall_any = stall_rename | stall_exec | stall_commit;
  assign flush_any = flush_commit | flush_rob;
  assign grp_src   = (st_q == ST_UNBLK) ? grp_head : grp_live;

  dec_skid #(.GW(GW), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr(skid_clr), .push(skid_push), .pop(skid_pop),
    .din(grp_live), .head(grp_head), .count(skid_count),
    .full(skid_full), .empty(skid_empty));

  dec_pack #(.W(LANES), .TAG_W(TAG_W), .PC_W(PC_W)) u_pack (
    .grp(grp_src), .o_valid(pk_valid), .o_ready(pk_ready), .o_tag(pk_tag),
    .o_count(pk_count), .o_redir(pk_redir), .o_redir_pc(pk_pc));

  always_comb begin
    st_d      = st_q;
    skid_push = 1'b0;
    skid_pop  = 1'b0;
    skid_clr  = 1'b0;
    emit      = 1'b0;
    hold_d    = 1'b0;
    redir_d   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_RUN, ST_UNBLK: begin
        if (flush_any) begin
          skid_clr = 1'b1;
          st_d     = ST_SQUASH;
        end else if (stall_any) begin
          skid_push = live_any;
          hold_d    = 1'b1;
          st_d      = ST_BLOCK;
        end else begin
          emit = 1'b1;
          if (pk_redir) begin
            skid_clr = 1'b1;
            redir_d  = 1'b1;
            st_d     = ST_SQUASH;
          end else if (st_q == ST_UNBLK) begin
            skid_push = live_any;
            skid_pop  = 1'b1;
            if (left_after_pop(skid_count, live_any)) hold_d = 1'b1;
            else st_d = ST_RUN;
          end else if (live_any) begin
            st_d = ST_RUN;
          end
        end
      end
      ST_BLOCK: begin
        skid_push = live_any;
        hold_d    = 1'b1;
        if (flush_any) begin
          skid_clr = 1'b1;
          hold_d   = 1'b0;
          st_d     = ST_SQUASH;
        end else if (!stall_any) begin
          st_d = (skid_empty && !live_any) ? ST_RUN : ST_UNBLK;
        end
      end
      default: begin
        if (!flush_any) st_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q              <= ST_IDLE;
      out_valid         <= '0;
      out_tag           <= '0;
      out_ready         <= '0;
      out_count         <= '0;
      fetch_hold        <= 1'b0;
      fetch_redirect    <= 1'b0;
      fetch_redirect_pc <= '0;
    end else begin
      st_q              <= st_d;
      out_valid         <= emit ? pk_valid : '0;
      out_tag           <= emit ? pk_tag   : '0;
      out_ready         <= emit ? pk_ready : '0;
      out_count         <= emit ? pk_count : '0;
      fetch_hold        <= hold_d;
      fetch_redirect    <= redir_d;
      fetch_redirect_pc <= redir_d ? pk_pc : '0;
    end
  end
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
  parameter int W     = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       state,
  input logic             skid_push,
  input logic             skid_pop,
  input logic             skid_full,
  input logic             skid_clr,
  input logic             stall_any,
  input logic             flush_any,
  input logic [W-1:0]     out_valid,
  input logic [CNT_W-1:0] out_count,
  input logic             fetch_hold,
  input logic             fetch_redirect
);
  localparam logic [2:0] S_BLOCK = 3'd2;
  localparam logic [2:0] S_UNBLK = 3'd3;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(skid_push && skid_full && !skid_pop && !skid_clr)); // R10

  AST_PACKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_valid) == int'(out_count)) && ((out_valid & (out_valid + 1'b1)) == '0)); // R2

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_any && !flush_any) |=> (out_count == '0) && !fetch_redirect); // R4

  AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLOCK) |-> fetch_hold); // R5

  AST_UNBLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UNBLK) |-> fetch_hold); // R6

  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> (out_count == '0) && !fetch_redirect && !fetch_hold); // R7

  AST_REDIRECT_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |=> (out_count == '0) && !fetch_redirect); // R9
endmodule

bind dec_stage dec_stage_chk #(.W(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st_q), .skid_push(skid_push),
  .skid_pop(skid_pop), .skid_full(skid_full), .skid_clr(skid_clr),
  .stall_any(stall_any), .flush_any(flush_any), .out_valid(out_valid),
  .out_count(out_count), .fetch_hold(fetch_hold), .fetch_redirect(fetch_redirect));

// File: tb/dec_stage_test.sv
module dec_stage_test;
  localparam int W = 4, TW = 8, PW = 16, D = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] in_valid, in_killed, in_is_ctrl, in_tgt_known, in_mispred, in_pred_taken, in_no_src;
  logic [W*TW-1:0] in_tag;
  logic [W*PW-1:0] in_next_pc;
  logic stall_rename, stall_exec, stall_commit, flush_commit, flush_rob;
  logic [W-1:0] out_valid, out_ready;
  logic [W*TW-1:0] out_tag;
  logic [CW-1:0] out_count;
  logic fetch_hold, fetch_redirect;
  logic [PW-1:0] fetch_redirect_pc;

  dec_stage #(.LANES(W), .TAG_W(TW), .PC_W(PW), .SKID_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_killed(in_killed),
    .in_is_ctrl(in_is_ctrl), .in_tgt_known(in_tgt_known), .in_mispred(in_mispred),
    .in_pred_taken(in_pred_taken), .in_no_src(in_no_src), .in_tag(in_tag),
    .in_next_pc(in_next_pc), .stall_rename(stall_rename), .stall_exec(stall_exec),
    .stall_commit(stall_commit), .flush_commit(flush_commit), .flush_rob(flush_rob),
    .out_valid(out_valid), .out_tag(out_tag), .out_ready(out_ready), .out_count(out_count),
    .fetch_hold(fetch_hold), .fetch_redirect(fetch_redirect), .fetch_redirect_pc(fetch_redirect_pc));

  typedef struct packed {
    logic [W-1:0] v, k, c, t, m, p, z;
    logic [W-1:0][TW-1:0] tag;
    logic [W-1:0][PW-1:0] npc;
  } grp_t;

  typedef enum int {M_IDLE, M_RUN, M_BLK, M_UNBLK, M_SQ} mst_e;

  mst_e ms;
  grp_t q[$];
  logic [W-1:0] e_valid, e_ready;
  logic [W*TW-1:0] e_tag;
  int e_count;
  logic e_hold, e_redir;
  logic [PW-1:0] e_pc;
  string e_lbl;
  int checks = 0, errors = 0, tag_seq = 1;
  logic cur_hold = 1'b0, lag_hold = 1'b0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit wrong_path(grp_t g, int i);
    if (g.c[i]) return g.t[i] && g.m[i];
    return g.p[i];
  endfunction

  // Expected rename output for one group; returns 1 when fetch must be redirected
  function automatic bit forward(grp_t g);
    for (int i = 0; i < W; i++) begin
      if (g.v[i] && !g.k[i]) begin
        e_tag[e_count*TW +: TW] = g.tag[i];
        e_ready[e_count] = g.z[i];
        e_valid[e_count] = 1'b1;
        e_count++;
        if (wrong_path(g, i)) begin
          e_pc = g.npc[i];
          return 1'b1;
        end
      end
    end
    return 1'b0;
  endfunction

  task automatic model(grp_t g, logic st, logic fl);
    bit live = (g.v != '0);
    e_valid = '0; e_ready = '0; e_tag = '0; e_count = 0;
    e_hold = 1'b0; e_redir = 1'b0; e_pc = '0;
    case (ms)
      M_IDLE, M_RUN, M_UNBLK: begin
        if (fl) begin
          q.delete(); ms = M_SQ; e_lbl = "R7";
        end else if (st) begin
          if (live) q.push_back(g);
          ms = M_BLK; e_hold = 1'b1; e_lbl = "R4";
        end else begin
          bit unb = (ms == M_UNBLK);
          grp_t src = unb ? ((q.size() != 0) ? q[0] : '0) : g;
          e_lbl = unb ? "R6" : "R2";
          if (forward(src)) begin
            e_redir = 1'b1; q.delete(); ms = M_SQ; e_lbl = "R9";
          end else if (unb) begin
            if (live) q.push_back(g);
            if (q.size() != 0) void'(q.pop_front());
            if (q.size() != 0) e_hold = 1'b1; else ms = M_RUN;
          end else if (live) ms = M_RUN;
        end
      end
      M_BLK: begin
        if (live) q.push_back(g);
        if (fl) begin
          q.delete(); ms = M_SQ; e_lbl = "R7";
        end else begin
          e_hold = 1'b1; e_lbl = "R5";
          if (!st) ms = (q.size() != 0) ? M_UNBLK : M_RUN;
        end
      end
      default: begin
        e_lbl = "R8";
        if (!fl) ms = M_RUN;
      end
    endcase
  endtask

  task automatic compare();
    chk(e_lbl, "out_count", 64'(out_count), 64'(e_count));
    chk(e_lbl, "out_valid", 64'(out_valid), 64'(e_valid));
    chk(e_lbl, "out_tag", 64'(out_tag), 64'(e_tag));
    chk("R3", "out_ready", 64'(out_ready), 64'(e_ready));
    chk(e_lbl, "fetch_hold", 64'(fetch_hold), 64'(e_hold));
    chk(e_lbl, "fetch_redirect", 64'(fetch_redirect), 64'(e_redir));
    chk(e_lbl, "redirect_pc", 64'(fetch_redirect_pc), 64'(e_pc));
  endtask

  task automatic sync();
    @(negedge clk);
    compare();
    lag_hold = cur_hold;
    cur_hold = fetch_hold;
  endtask

  task automatic drive(grp_t g, logic sr, logic se, logic sc, logic fc, logic fr);
    in_valid = g.v; in_killed = g.k; in_is_ctrl = g.c; in_tgt_known = g.t;
    in_mispred = g.m; in_pred_taken = g.p; in_no_src = g.z;
    in_tag = g.tag; in_next_pc = g.npc;
    stall_rename = sr; stall_exec = se; stall_commit = sc;
    flush_commit = fc; flush_rob = fr;
    model(g, sr | se | sc, fc | fr);
  endtask

  task automatic cyc(grp_t g, logic sr, logic se, logic sc, logic fc, logic fr);
    sync();
    drive(g, sr, se, sc, fc, fr);
  endtask

  function automatic grp_t plain_grp();
    grp_t g = '0;
    for (int i = 0; i < W; i++) begin
      g.v[i] = 1'b1;
      g.z[i] = i[0];
      g.tag[i] = TW'(tag_seq++);
      g.npc[i] = PW'(16'h1000 + tag_seq * 4);
    end
    return g;
  endfunction

  function automatic grp_t rand_grp();
    grp_t g = '0;
    for (int i = 0; i < W; i++) begin
      g.v[i] = ($urandom % 5) != 0;
      g.k[i] = ($urandom % 6) == 0;
      g.c[i] = ($urandom % 4) == 0;
      g.t[i] = ($urandom % 2) == 0;
      g.m[i] = ($urandom % 4) == 0;
      g.p[i] = ($urandom % 12) == 0;
      g.z[i] = ($urandom % 2) == 0;
      g.tag[i] = TW'(tag_seq++);
      g.npc[i] = PW'($urandom);
    end
    return g;
  endfunction

  task automatic settle();
    for (int i = 0; i < 8; i++) cyc('0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    grp_t g;
    int drained;
    void'($urandom(32'h5eed_0d3c));
    drive('0, 0, 0, 0, 0, 0);
    ms = M_IDLE;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "out_count at reset", 64'(out_count), 0);
    chk("R1", "fetch_hold at reset", 64'(fetch_hold), 0);
    chk("R1", "fetch_redirect at reset", 64'(fetch_redirect), 0);
    chk("R1", "out_tag at reset", 64'(out_tag), 0);
    rst_n = 1'b1;
    drive('0, 0, 0, 0, 0, 0);

    // R2 R3: killed lanes dropped, packing from slot 0
    g = plain_grp(); g.k[0] = 1'b1; g.v[2] = 1'b0; g.z[3] = 1'b1;
    cyc(g, 0, 0, 0, 0, 0);
    cyc(plain_grp(), 0, 0, 0, 0, 0);

    // R7: stall and flush together, flush wins; R8 release next cycle
    cyc(plain_grp(), 1, 0, 1, 1, 0);
    cyc(plain_grp(), 0, 0, 0, 0, 1);
    cyc(plain_grp(), 0, 0, 0, 0, 0);
    cyc(plain_grp(), 0, 0, 0, 0, 0);

    // R9: mispredict in lane 1, and a non-control predicted taken in lane 0
    g = plain_grp(); g.c[1] = 1'b1; g.t[1] = 1'b1; g.m[1] = 1'b1; g.npc[1] = 16'hBEEF;
    cyc(g, 0, 0, 0, 0, 0);
    cyc('0, 0, 0, 0, 0, 0);
    g = plain_grp(); g.p[0] = 1'b1; g.npc[0] = 16'h4242;
    g.k[1] = 1'b1; g.c[1] = 1'b1; g.t[1] = 1'b1; g.m[1] = 1'b1;
    cyc(g, 0, 0, 0, 0, 0);
    cyc('0, 0, 0, 0, 0, 0);
    settle();

    // R4 R5 R6 R9: stall on a mispredicting group, drain it while a live group arrives
    g = plain_grp(); g.c[2] = 1'b1; g.t[2] = 1'b1; g.m[2] = 1'b1; g.npc[2] = 16'hCAFE;
    cyc(g, 0, 1, 0, 0, 0);
    cyc('0, 0, 0, 0, 0, 0);
    cyc(plain_grp(), 0, 0, 0, 0, 0);
    settle();

    // R10 R6: fill the buffer to its depth, then push while popping at full
    cyc(plain_grp(), 1, 0, 0, 0, 0);
    for (int i = 1; i < D; i++) cyc(plain_grp(), 0, 0, 1, 0, 0);
    cyc('0, 0, 0, 0, 0, 0);
    cyc(plain_grp(), 0, 0, 0, 0, 0);
    drained = 0;
    for (int i = 0; i < D + 1; i++) begin
      cyc('0, 0, 0, 0, 0, 0);
      if (out_count != '0) drained++;
    end
    chk("R10", "groups drained from full buffer", 64'(drained), 64'(D + 1));
    settle();

    // Random traffic; fetch reacts to fetch_hold one cycle late
    for (int n = 0; n < 2500; n++) begin
      bit send;
      sync();
      send = !lag_hold && (($urandom % 4) != 0);
      g = send ? rand_grp() : '0;
      drive(g, ($urandom % 100) < 8, ($urandom % 100) < 4, ($urandom % 100) < 4,
            ($urandom % 100) < 3, ($urandom % 100) < 2);
    end
    sync();
    done = 1'b1;
    finish_run();
  end
endmodule